// File: doc/BRIEF.md
# TBI Link Bring-Up Sequencer

This block brings the on-chip ten-bit-interface coding layer into serial gigabit operation after reset without any help from software. When it is started, and only when the interface mode straps select both serial-gigabit operation and the ten-bit interface, it plays a fixed script of management operations through a request/acknowledge port to a management (MDIO) master. The master owns the bus framing; this block only decides what is sent, and when.

The script first sets the management clock divider in the master, then captures the power-up contents of the coding layer's control register. It then selects single-clock operation with the MII path disabled, advertises full duplex with both pause kinds and no half duplex, and enables and restarts auto-negotiation at 1000 Mb/s full duplex. Every operation waits for the master to report idle before the next one is issued. The block then polls the status register until negotiation is complete and the link is up, or until a poll budget is spent. The result is reported on `done`, `link_up` and `error`.

Top module: `tbi_linkup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `mgmt_req`, `done`, `link_up` and `error` are all 0.
- R2: A `start` pulse is accepted only when both `sgmii_en` and `tbi_en` are 1; otherwise no request is made and `done` stays 0.
- R3: An accepted start issues, in this order, with `mgmt_op` encoded 00 = master clock configuration write, 01 = register write, 10 = register read: op 00 data 0x0005; op 10 register 0x00; op 01 register 0x11 data 0x0020; op 01 register 0x04 data 0x01A0; op 01 register 0x00 data 0x1340; then op 10 register 0x02 repeated as status polls.
- R4: Every register read or write carries `phy_addr` on `mgmt_phy`; the clock configuration write carries 0 on `mgmt_phy` and `mgmt_reg`.
- R5: `mgmt_req` stays 1 with every request field unchanged until `mgmt_ack` is seen, and each acknowledge ends exactly one request.
- R6: After an acknowledge no new request rises until `mgmt_busy` has been observed 0 (the master holds `mgmt_busy` at 1 from the cycle after the acknowledge until the operation ends, with read data valid once it falls).
- R7: The data returned by the register 0x00 read appears on `ctrl_snapshot` and is held until the next accepted start.
- R8: A status poll with both bit 5 (negotiation complete) and bit 2 (link up) set ends the run with `done` = 1 and `link_up` = 1; a status with either bit clear triggers another poll after `POLL_GAP` idle cycles.
- R9: When `MAX_POLLS` status polls have all failed, the run ends with `done` = 1, `error` = 1, `link_up` = 0 and no further requests.
- R10: A `start` during a run is ignored; a `start` after the run has ended clears `done`, `link_up` and `error` in the next cycle and replays the whole script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| sgmii_en | input | 1 | Serial-gigabit mode selected |
| tbi_en | input | 1 | Ten-bit interface selected |
| phy_addr | input | PHY_AW | Management address of the coding layer |
| mgmt_req | output | 1 | Request to the management master |
| mgmt_ack | input | 1 | Request accepted by the master |
| mgmt_op | output | 2 | Operation code (see R3) |
| mgmt_phy | output | PHY_AW | Target address |
| mgmt_reg | output | 5 | Target register |
| mgmt_wdata | output | 16 | Write data |
| mgmt_rdata | input | 16 | Read data from the master |
| mgmt_busy | input | 1 | Master operation in progress |
| ctrl_snapshot | output | 16 | Captured power-up control register |
| done | output | 1 | Run finished |
| link_up | output | 1 | Run finished with link established |
| error | output | 1 | Run finished with poll budget spent |

## Verification
The two functions that can meet in one cycle are the end of the run and the acceptance of a new start: the master model raises `start` in exactly the cycle it drops `mgmt_busy` for the successful status poll, so the sequencer sees both at the same edge. The run must finish with `link_up` set, and the start must be treated as one that arrived during the run, so no request follows within the next forty cycles. A second contest, a start halfway through the script, is judged the same way by counting the operations the master receives.

// File: rtl/tbi_seq_pkg.sv
// Shared types and script constants for the TBI bring-up sequencer.
// Assumes a 5-bit register space and 16-bit register data on the management bus.
package tbi_seq_pkg;
    localparam int REG_AW = 5;
    localparam int DW     = 16;

    typedef enum logic [1:0] {
        OP_CFG_WR  = 2'b00,
        OP_MDIO_WR = 2'b01,
        OP_MDIO_RD = 2'b10
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e          op;
        logic [REG_AW-1:0] regno;
        logic [DW-1:0]     data;
    } step_t;

    localparam int NUM_STEPS      = 6;
    localparam int STEP_W         = $clog2(NUM_STEPS);
    localparam int CTRL_READ_STEP = 1;
    localparam int STATUS_STEP    = NUM_STEPS - 1;

    localparam logic [REG_AW-1:0] REG_CTRL   = 5'h00;
    localparam logic [REG_AW-1:0] REG_STATUS = 5'h02;
    localparam logic [REG_AW-1:0] REG_ADV    = 5'h04;
    localparam logic [REG_AW-1:0] REG_IFCFG  = 5'h11;

    localparam logic [DW-1:0] VAL_MGMT_CLK = 16'h0005;
    localparam logic [DW-1:0] VAL_IFCFG    = 16'h0020;
    localparam logic [DW-1:0] VAL_ADV      = 16'h01A0;
    localparam logic [DW-1:0] VAL_CTRL     = 16'h1340;

    localparam int BIT_AN_DONE = 5;
    localparam int BIT_LINK    = 2;
endpackage

// File: rtl/tbi_step_table.sv
// Fixed bring-up script: maps a step index to the operation it performs.
// Assumes indices past the last step are never presented; they map to the status poll.
module tbi_step_table
    import tbi_seq_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             cmd
);
    // Decode the step index into operation, register and data.
    always_comb begin
        unique case (idx)
            3'd0:    cmd = '{op: OP_CFG_WR,  regno: '0,        data: VAL_MGMT_CLK};
            3'd1:    cmd = '{op: OP_MDIO_RD, regno: REG_CTRL,  data: '0};
            3'd2:    cmd = '{op: OP_MDIO_WR, regno: REG_IFCFG, data: VAL_IFCFG};
            3'd3:    cmd = '{op: OP_MDIO_WR, regno: REG_ADV,   data: VAL_ADV};
            3'd4:    cmd = '{op: OP_MDIO_WR, regno: REG_CTRL,  data: VAL_CTRL};
            default: cmd = '{op: OP_MDIO_RD, regno: REG_STATUS, data: '0};
        endcase
    end
endmodule

// File: rtl/tbi_mgmt_xact.sv
// One management transaction: latches a command on go, holds the request
// until acknowledged, then waits for the master's busy flag to fall.
// Assumes busy is high from the cycle after ack until the operation ends.
module tbi_mgmt_xact
    import tbi_seq_pkg::*;
#(
    parameter int PHY_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  step_t             cmd,
    input  logic [PHY_AW-1:0] phy_addr,
    output logic              mgmt_req,
    input  logic              mgmt_ack,
    output logic [1:0]        mgmt_op,
    output logic [PHY_AW-1:0] mgmt_phy,
    output logic [REG_AW-1:0] mgmt_reg,
    output logic [DW-1:0]     mgmt_wdata,
    input  logic              mgmt_busy,
    output logic              xact_done
);
    typedef enum logic [1:0] {X_IDLE, X_REQ, X_WAIT} xstate_e;

    xstate_e           xs;
    step_t             cmd_q;
    logic [PHY_AW-1:0] phy_q;
    logic              is_cfg;

    // Transaction state and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs    <= X_IDLE;
            cmd_q <= '0;
            phy_q <= '0;
        end else begin
            unique case (xs)
                X_IDLE: if (go) begin
                    cmd_q <= cmd;
                    phy_q <= phy_addr;
                    xs    <= X_REQ;
                end
                X_REQ:   if (mgmt_ack) xs <= X_WAIT;
                X_WAIT:  if (!mgmt_busy) xs <= X_IDLE;
                default: xs <= X_IDLE;
            endcase
        end
    end

    // Request fields presented from the latched command.
    always_comb begin
        is_cfg     = (cmd_q.op == OP_CFG_WR);
        mgmt_req   = (xs == X_REQ);
        mgmt_op    = cmd_q.op;
        mgmt_phy   = is_cfg ? '0 : phy_q;
        mgmt_reg   = is_cfg ? '0 : cmd_q.regno;
        mgmt_wdata = (cmd_q.op == OP_MDIO_RD) ? '0 : cmd_q.data;
        xact_done  = (xs == X_WAIT) && !mgmt_busy;
    end
endmodule

// File: rtl/tbi_poll_track.sv
// Judges each status poll and counts failed polls against the budget.
// Assumes eval is a single-cycle pulse with status valid in that cycle.
module tbi_poll_track
    import tbi_seq_pkg::*;
#(
    parameter int MAX_POLLS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          eval,
    input  logic [DW-1:0] status,
    output logic          ok,
    output logic          expired
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] fails;
    logic             st_good;

    // Success needs both negotiation complete and link up.
    always_comb begin
        st_good = status[BIT_AN_DONE] && status[BIT_LINK];
        ok      = eval && st_good;
        expired = eval && !st_good && (fails == CNT_W'(MAX_POLLS - 1));
    end

    // Failed-poll counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fails <= '0;
        end else if (eval && !st_good) begin
            fails <= fails + 1'b1;
        end
    end
endmodule

// File: rtl/tbi_linkup_seq.sv
// Top of the TBI bring-up sequencer: walks the step table, runs each step
// through the transaction engine, then polls status with a gap and a budget.
// Assumes phy_addr and the mode straps are stable during a run; POLL_GAP >= 1.
module tbi_linkup_seq
    import tbi_seq_pkg::*;
#(
    parameter int PHY_AW    = 5,
    parameter int MAX_POLLS = 8,
    parameter int POLL_GAP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sgmii_en,
    input  logic              tbi_en,
    input  logic [PHY_AW-1:0] phy_addr,
    output logic              mgmt_req,
    input  logic              mgmt_ack,
    output logic [1:0]        mgmt_op,
    output logic [PHY_AW-1:0] mgmt_phy,
    output logic [4:0]        mgmt_reg,
    output logic [15:0]       mgmt_wdata,
    input  logic [15:0]       mgmt_rdata,
    input  logic              mgmt_busy,
    output logic [15:0]       ctrl_snapshot,
    output logic              done,
    output logic              link_up,
    output logic              error
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);

    typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_GAP, ST_FIN} state_e;

    state_e            state;
    logic [STEP_W-1:0] step;
    logic [GAP_W-1:0]  gap_cnt;
    step_t             cur_cmd;
    logic              go;
    logic              xact_done;
    logic              start_ok;
    logic              poll_eval;
    logic              poll_ok;
    logic              poll_expired;

    tbi_step_table u_table (
        .idx (step),
        .cmd (cur_cmd)
    );

    tbi_mgmt_xact #(.PHY_AW(PHY_AW)) u_xact (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cmd        (cur_cmd),
        .phy_addr   (phy_addr),
        .mgmt_req   (mgmt_req),
        .mgmt_ack   (mgmt_ack),
        .mgmt_op    (mgmt_op),
        .mgmt_phy   (mgmt_phy),
        .mgmt_reg   (mgmt_reg),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_busy  (mgmt_busy),
        .xact_done  (xact_done)
    );

    tbi_poll_track #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_ok),
        .eval    (poll_eval),
        .status  (mgmt_rdata),
        .ok      (poll_ok),
        .expired (poll_expired)
    );

    // Start qualification and per-cycle strobes.
    always_comb begin
        start_ok  = start && sgmii_en && tbi_en && (state == ST_IDLE || state == ST_FIN);
        go        = (state == ST_ISSUE);
        poll_eval = (state == ST_WAIT) && xact_done && (step == STEP_W'(STATUS_STEP));
    end

    // Sequencer state, step index, gap timer and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            step          <= '0;
            gap_cnt       <= '0;
            ctrl_snapshot <= '0;
            done          <= 1'b0;
            link_up       <= 1'b0;
            error         <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_FIN: if (start_ok) begin
                    step    <= '0;
                    done    <= 1'b0;
                    link_up <= 1'b0;
                    error   <= 1'b0;
                    state   <= ST_ISSUE;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: if (xact_done) begin
                    if (step == STEP_W'(CTRL_READ_STEP)) ctrl_snapshot <= mgmt_rdata;
                    if (step != STEP_W'(STATUS_STEP)) begin
                        step  <= step + 1'b1;
                        state <= ST_ISSUE;
                    end else if (poll_ok) begin
                        done    <= 1'b1;
                        link_up <= 1'b1;
                        state   <= ST_FIN;
                    end else if (poll_expired) begin
                        done  <= 1'b1;
                        error <= 1'b1;
                        state <= ST_FIN;
                    end else begin
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(POLL_GAP - 1)) begin
                        state <= ST_ISSUE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tbi_linkup_seq_chk.sv
// Protocol and result checker for the TBI bring-up sequencer, bound to the top.
// Assumes the master raises busy the cycle after ack, as the top does.
module tbi_linkup_seq_chk #(
    parameter int PHY_AW    = 5,
    parameter int MAX_POLLS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHY_AW-1:0] phy_addr,
    input logic              mgmt_req,
    input logic              mgmt_ack,
    input logic [1:0]        mgmt_op,
    input logic [PHY_AW-1:0] mgmt_phy,
    input logic [4:0]        mgmt_reg,
    input logic [15:0]       mgmt_wdata,
    input logic [15:0]       mgmt_rdata,
    input logic              mgmt_busy,
    input logic              done,
    input logic              link_up,
    input logic              error
);
    localparam int PC_W = $clog2(MAX_POLLS + 2) + 1;

    logic [PC_W-1:0] poll_cnt;
    logic            req_q;
    logic            done_q;

    // Count status polls issued within the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            req_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            req_q  <= mgmt_req;
            done_q <= done;
            if (done_q && !done) begin
                poll_cnt <= '0;
            end else if (mgmt_req && !req_q && mgmt_op == 2'b10 && mgmt_reg == 5'h02) begin
                poll_cnt <= poll_cnt + 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!mgmt_req && !done && !link_up && !error)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_op) && $stable(mgmt_reg)
                                     && $stable(mgmt_wdata) && $stable(mgmt_phy))); // R5

    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_req) |-> !mgmt_busy); // R6

    AST_PHY_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && mgmt_op != 2'b00) |-> (mgmt_phy == phy_addr)); // R4

    AST_LINK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(mgmt_rdata[5] && mgmt_rdata[2])); // R8

    AST_LINK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (done && !error)); // R8

    AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R9

    AST_POLL_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PC_W'(MAX_POLLS)); // R9
endmodule

bind tbi_linkup_seq tbi_linkup_seq_chk #(
    .PHY_AW    (PHY_AW),
    .MAX_POLLS (MAX_POLLS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phy_addr   (phy_addr),
    .mgmt_req   (mgmt_req),
    .mgmt_ack   (mgmt_ack),
    .mgmt_op    (mgmt_op),
    .mgmt_phy   (mgmt_phy),
    .mgmt_reg   (mgmt_reg),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata),
    .mgmt_busy  (mgmt_busy),
    .done       (done),
    .link_up    (link_up),
    .error      (error)
);

// File: tb/tbi_linkup_seq_bench.sv
// Directed bench: a behavioural management master logs every request and
// answers reads; one task per scenario checks its own results.
module tbi_linkup_seq_bench;
    localparam int TB_MAX   = 5;
    localparam int TB_GAP   = 3;
    localparam int BUSY_LEN = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_t = 1'b0;
    logic        start_c = 1'b0;
    logic        sgmii_en = 1'b1;
    logic        tbi_en = 1'b1;
    logic [4:0]  phy_addr = 5'd16;
    logic        mgmt_req;
    logic        mgmt_ack = 1'b0;
    logic [1:0]  mgmt_op;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic [15:0] mgmt_wdata;
    logic [15:0] mgmt_rdata = 16'h0;
    logic        mgmt_busy = 1'b0;
    logic [15:0] ctrl_snapshot;
    logic        done;
    logic        link_up;
    logic        error;

    int n_chk = 0;
    int n_fail = 0;

    // master model state
    int          log_n = 0;
    logic [1:0]  log_op [64];
    logic [4:0]  log_reg [64];
    logic [4:0]  log_phy [64];
    logic [15:0] log_data [64];
    logic [15:0] stat_seq [8];
    int          stat_len = 1;
    int          stat_idx = 0;
    logic [15:0] ctrl_default = 16'h1140;
    int          ack_delay = 0;
    int          viol = 0;
    int          hold_err = 0;
    logic        collide = 1'b0;

    always #2 clk = ~clk;

    tbi_linkup_seq #(.PHY_AW(5), .MAX_POLLS(TB_MAX), .POLL_GAP(TB_GAP)) u_tbi_linkup_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_t | start_c),
        .sgmii_en      (sgmii_en),
        .tbi_en        (tbi_en),
        .phy_addr      (phy_addr),
        .mgmt_req      (mgmt_req),
        .mgmt_ack      (mgmt_ack),
        .mgmt_op       (mgmt_op),
        .mgmt_phy      (mgmt_phy),
        .mgmt_reg      (mgmt_reg),
        .mgmt_wdata    (mgmt_wdata),
        .mgmt_rdata    (mgmt_rdata),
        .mgmt_busy     (mgmt_busy),
        .ctrl_snapshot (ctrl_snapshot),
        .done          (done),
        .link_up       (link_up),
        .error         (error)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural master: ack after a delay, busy for BUSY_LEN cycles, then data.
    initial begin
        int phase = 0;
        int wcnt = 0;
        int bcnt = 0;
        logic [15:0] pend;
        pend = '0;
        forever begin
            @(negedge clk);
            start_c = 1'b0;
            if (phase == 0) begin
                if (mgmt_req) begin
                    if (mgmt_busy) viol++;
                    if (wcnt < ack_delay) begin
                        wcnt++;
                    end else begin
                        mgmt_ack = 1'b1;
                        wcnt = 0;
                        if (log_n < 64) begin
                            log_op[log_n]   = mgmt_op;
                            log_reg[log_n]  = mgmt_reg;
                            log_phy[log_n]  = mgmt_phy;
                            log_data[log_n] = mgmt_wdata;
                        end
                        log_n++;
                        pend = 16'h0;
                        if (mgmt_op == 2'b10 && mgmt_reg == 5'h00) pend = ctrl_default;
                        if (mgmt_op == 2'b10 && mgmt_reg == 5'h02) begin
                            pend = stat_seq[(stat_idx < stat_len) ? stat_idx : stat_len - 1];
                            stat_idx++;
                        end
                        phase = 1;
                    end
                end else if (wcnt > 0) begin
                    hold_err++;
                    wcnt = 0;
                end
            end else if (phase == 1) begin
                mgmt_ack = 1'b0;
                mgmt_busy = 1'b1;
                bcnt = 1;
                phase = 2;
            end else begin
                if (mgmt_req) viol++;
                if (bcnt >= BUSY_LEN) begin
                    mgmt_busy = 1'b0;
                    mgmt_rdata = pend;
                    if (collide && pend[5] && pend[2]) begin
                        start_c = 1'b1;
                        collide = 1'b0;
                    end
                    phase = 0;
                end else begin
                    bcnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    task automatic pulse_start();
        @(negedge clk);
        start_t = 1'b1;
        @(negedge clk);
        start_t = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic new_run(input logic [15:0] s0, input logic [15:0] s1,
                           input logic [15:0] s2, input logic [15:0] s3, input int len);
        stat_seq[0] = s0; stat_seq[1] = s1; stat_seq[2] = s2; stat_seq[3] = s3;
        stat_len = len;
        stat_idx = 0;
        log_n = 0;
        viol = 0;
        hold_err = 0;
    endtask

    task automatic check_script(input string tag, input int polls);
        logic [1:0]  eop [5] = '{2'b00, 2'b10, 2'b01, 2'b01, 2'b01};
        logic [4:0]  ereg [5] = '{5'h00, 5'h00, 5'h11, 5'h04, 5'h00};
        logic [15:0] edat [5] = '{16'h0005, 16'h0000, 16'h0020, 16'h01A0, 16'h1340};
        chk({tag, " R3 op count"}, log_n, 5 + polls);
        for (int i = 0; i < 5 + polls && i < 64; i++) begin
            if (i < 5) begin
                chk({tag, " R3 op"}, log_op[i], eop[i]);
                chk({tag, " R3 reg"}, log_reg[i], ereg[i]);
                chk({tag, " R3 data"}, log_data[i], edat[i]);
                chk({tag, " R4 phy"}, log_phy[i], (i == 0) ? 5'd0 : phy_addr);
            end else begin
                chk({tag, " R3 poll op"}, log_op[i], 2'b10);
                chk({tag, " R3 poll reg"}, log_reg[i], 5'h02);
                chk({tag, " R4 poll phy"}, log_phy[i], phy_addr);
            end
        end
        chk({tag, " R6 request while busy"}, viol, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", mgmt_req, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", {link_up, error, done, mgmt_req}, 4'b0);
    endtask

    task automatic t_gating();
        new_run(16'h0024, 0, 0, 0, 1);
        sgmii_en = 1'b1; tbi_en = 1'b0;
        pulse_start();
        repeat (40) @(negedge clk);
        chk("R2 no request with tbi off", log_n, 0);
        chk("R2 done with tbi off", done, 0);
        sgmii_en = 1'b0; tbi_en = 1'b1;
        pulse_start();
        repeat (40) @(negedge clk);
        chk("R2 no request with sgmii off", log_n, 0);
        chk("R2 done with sgmii off", done, 0);
        sgmii_en = 1'b1;
    endtask

    task automatic t_nominal();
        phy_addr = 5'd16;
        ctrl_default = 16'h1140;
        new_run(16'h0024, 0, 0, 0, 1);
        pulse_start();
        wait_done();
        check_script("nominal", 1);
        chk("R7 snapshot", ctrl_snapshot, 16'h1140);
        chk("R8 result", {done, link_up, error}, 3'b110);
    endtask

    task automatic t_partial();
        phy_addr = 5'd5;
        ctrl_default = 16'h0A55;
        new_run(16'h0020, 16'h0004, 16'h0000, 16'h0024, 4);
        pulse_start();
        wait_done();
        check_script("partial", 4);
        chk("R7 snapshot second run", ctrl_snapshot, 16'h0A55);
        chk("R8 result after partial status", {done, link_up, error}, 3'b110);
    endtask

    task automatic t_timeout();
        phy_addr = 5'd9;
        new_run(16'h0020, 0, 0, 0, 1);
        pulse_start();
        wait_done();
        check_script("timeout", TB_MAX);
        chk("R9 result", {done, link_up, error}, 3'b101);
        repeat (40) @(negedge clk);
        chk("R9 no further requests", log_n, 5 + TB_MAX);
    endtask

    task automatic t_restart();
        new_run(16'h0024, 0, 0, 0, 1);
        pulse_start();
        chk("R10 flags cleared on restart", {done, link_up, error}, 3'b000);
        wait_done();
        chk("R10 full replay", log_n, 6);
        chk("R10 restart result", {done, link_up, error}, 3'b110);
    endtask

    task automatic t_ack_delay();
        ack_delay = 6;
        new_run(16'h0024, 0, 0, 0, 1);
        pulse_start();
        wait_done();
        chk("R5 request dropped before ack", hold_err, 0);
        check_script("ackdelay", 1);
        ack_delay = 0;
    endtask

    task automatic t_mid_start();
        new_run(16'h0024, 0, 0, 0, 1);
        pulse_start();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (log_n >= 2) break;
        end
        pulse_start();
        wait_done();
        repeat (30) @(negedge clk);
        chk("R10 start during run ignored", log_n, 6);
        chk("R10 result after ignored start", {done, link_up}, 2'b11);
    endtask

    task automatic t_collide();
        new_run(16'h0024, 0, 0, 0, 1);
        collide = 1'b1;
        pulse_start();
        wait_done();
        repeat (40) @(negedge clk);
        chk("R10 start at final poll ignored", log_n, 6);
        chk("R8 link at collision", {done, link_up, error}, 3'b110);
    endtask

    initial begin
        t_reset();
        t_gating();
        t_nominal();
        t_partial();
        t_timeout();
        t_restart();
        t_ack_delay();
        t_mid_start();
        t_collide();
        report();
        $finish;
    end
endmodule